// File: doc/BRIEF.md
# Prescaled Watchdog Timer With Reload

This block is a runaway-software detector. A down-counter counts ticks from a prescaler that divides the bus clock. When the counter passes below zero, the block raises a one-cycle interrupt request and reloads the counter to its full value, so a stalled program sees the timeout again on every period. Software keeps the interrupt from firing by strobing the start input often enough, and each strobe reloads the counter to full scale.

The prescaler ratio depends on which oscillator drives the bus clock. On the main oscillator, a control bit selects divide-by-16 or divide-by-128. On the sub oscillator, the ratio is always divide-by-2. A hold input suspends the prescaler and the counter. The first strobe starts the watchdog, and after that only a system reset stops it.

The counter width and the three ratios are parameters. With the default 15-bit counter the timeout is the ratio times 32768 bus-clock cycles, which is about 32.8 ms at 16 MHz with the /16 ratio.

Top module: `wdt_top`

## Requirements
- R1: After reset the count reads all ones (0x7FFF at the default width) and irq is low. The count stays there, whatever hold and the ratio inputs do, until the first start strobe.
- R2: A start strobe sampled at a clock edge sets the count to all ones and clears the prescaler at that edge. This applies both to the first start and to a strobe while the watchdog runs (a kick), and a strobe takes priority over any tick in the same cycle.
- R3: With clk_sub_sel = 0 and div_hi = 0, the count drops by one every 16 running, unheld cycles, with the first decrement 16 cycles after the start edge.
- R4: With clk_sub_sel = 0 and div_hi = 1, the count drops by one every 128 running, unheld cycles.
- R5: With clk_sub_sel = 1, the count drops by one every 2 running, unheld cycles, whatever the value of div_hi.
- R6: When a tick arrives at count zero, the count reloads to all ones and irq is high for exactly one cycle, starting at that edge. Interrupts therefore repeat every ratio × 2^CNT_W unheld cycles.
- R7: While hold is high and no start strobe is present, neither the count nor the prescaler advances. Counting resumes from the same phase when hold falls.
- R8: Once started, the watchdog keeps counting with no further strobes, and no input other than rst_n stops it. A reset returns it to the stopped state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clk_sub_sel | input | 1 | 1: sub oscillator drives the bus clock (ratio fixed at /2) |
| div_hi | input | 1 | Main-oscillator ratio select: 0 gives /16, 1 gives /128 |
| start_wr | input | 1 | Start-register write strobe: starts the watchdog or reloads it |
| hold | input | 1 | Freezes the prescaler and the counter while high |
| irq | output | 1 | One-cycle watchdog interrupt request |
| count | output | CNT_W | Current counter value |

## Verification
Every result appears at the clock edge that samples its cause. A strobe makes the count read all ones and irq read low right after that edge. The k-th decrement follows the k-th multiple of the ratio in running, unheld cycles counted from the start edge. The irq pulse follows the edge that ends the ratio × 2^CNT_W-th such cycle. The bench counts those unheld cycles arithmetically and derives the expected count and irq from that number. It drives inputs and compares outputs on the falling edge, so every check sees the state the preceding rising edge produced. It uses a 5-bit counter so that whole periods of all three ratios, kicks, hold patterns and a reset in the middle of a run fit in a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        RATIO_MAIN_LO = 2'd0,
        RATIO_MAIN_HI = 2'd1,
        RATIO_SUB     = 2'd2
    } ratio_sel_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int DIV_LO  = 16,
    parameter int DIV_HI  = 128,
    parameter int DIV_SUB = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic sub_sel,
    input  logic ratio_hi,
    output logic tick
);

    localparam int DMAX = max3(DIV_LO, DIV_HI, DIV_SUB);
    localparam int PW   = (DMAX > 2) ? $clog2(DMAX) : 1;

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_state_t;

    pre_state_t s_d, s_q;
    ratio_sel_e sel;
    logic [PW-1:0] last;

    always_comb begin
        if (sub_sel)       sel = RATIO_SUB;
        else if (ratio_hi) sel = RATIO_MAIN_HI;
        else               sel = RATIO_MAIN_LO;

        case (sel)
            RATIO_MAIN_HI: last = PW'(DIV_HI - 1);
            RATIO_SUB:     last = PW'(DIV_SUB - 1);
            default:       last = PW'(DIV_LO - 1);
        endcase

        tick = en && (s_q.phase >= last);

        s_d = s_q;
        if (clr)       s_d.phase = '0;
        else if (tick) s_d.phase = '0;
        else if (en)   s_d.phase = s_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7
    hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(s_q.phase));

    // R2
    clr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.phase == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    output logic [CNT_W-1:0] value,
    output logic             underflow
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             uf;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.uf = 1'b0;
        if (load) begin
            s_d.cnt = FULL;
        end else if (tick) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = FULL;
                s_d.uf  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= FULL;
            s_q.uf  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign value     = s_q.cnt;
    assign underflow = s_q.uf;

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != $past(s_q.cnt)) |-> ((s_q.cnt == $past(s_q.cnt) - 1'b1) || (s_q.cnt == FULL)));

    // R6
    irq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.uf |-> (s_q.cnt == FULL));

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.uf |=> !s_q.uf);

endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
    parameter int CNT_W   = 15,
    parameter int DIV_LO  = 16,
    parameter int DIV_HI  = 128,
    parameter int DIV_SUB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_sub_sel,
    input  logic             div_hi,
    input  logic             start_wr,
    input  logic             hold,
    output logic             irq,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    typedef struct packed {
        logic running;
    } top_state_t;

    top_state_t s_d, s_q;
    logic pre_en;
    logic pre_tick;

    always_comb begin
        s_d         = s_q;
        s_d.running = s_q.running | start_wr;
        pre_en      = s_q.running && !hold && !start_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    wdt_prescaler #(
        .DIV_LO  (DIV_LO),
        .DIV_HI  (DIV_HI),
        .DIV_SUB (DIV_SUB)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pre_en),
        .clr      (start_wr),
        .sub_sel  (clk_sub_sel),
        .ratio_hi (div_hi),
        .tick     (pre_tick)
    );

    wdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_wr),
        .tick      (pre_tick),
        .value     (count),
        .underflow (irq)
    );

    // R8
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.running |=> s_q.running);

    // R1
    idle_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.running |-> (count == FULL && !irq));

    // R7
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !start_wr) |=> ($stable(count) && !irq));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (count == FULL && !irq));

endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;

    localparam int W    = 5;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_sub_sel = 1'b0;
    logic div_hi = 1'b0;
    logic start_wr = 1'b0;
    logic hold = 1'b0;
    logic irq;
    logic [W-1:0] count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit run_m = 1'b0;
    int n_m = 0;

    always #2 clk = ~clk;

    wdt_top #(.CNT_W(W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_sub_sel (clk_sub_sel),
        .div_hi      (div_hi),
        .start_wr    (start_wr),
        .hold        (hold),
        .irq         (irq),
        .count       (count)
    );

    function automatic int ratio_now();
        if (clk_sub_sel) return 2;
        if (div_hi)      return 128;
        return 16;
    endfunction

    task automatic check_out(input string tag, input int exp_cnt, input bit exp_irq);
        checks++;
        if (int'(count) != exp_cnt || irq != exp_irq) begin
            errors++;
            $display("FAIL %s count=%0d irq=%0d expected count=%0d irq=%0d",
                     tag, count, irq, exp_cnt, exp_irq);
        end
    endtask

    // one clock: drive at falling edge, model the rising edge, check at next falling edge
    task automatic cyc(input string tag, input bit st, input bit hd);
        bit inc;
        int r;
        int exp_cnt;
        bit exp_irq;
        start_wr = st;
        hold     = hd;
        @(posedge clk);
        inc = 1'b0;
        if (st) begin
            run_m = 1'b1;
            n_m   = 0;
        end else if (run_m && !hd) begin
            n_m++;
            inc = 1'b1;
        end
        @(negedge clk);
        r       = ratio_now();
        exp_cnt = MAXV - ((n_m / r) % (MAXV + 1));
        exp_irq = inc && (n_m % (r * (MAXV + 1)) == 0);
        check_out(tag, exp_cnt, exp_irq);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        start_wr = 1'b0;
        hold     = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        run_m = 1'b0;
        n_m   = 0;
        check_out("R1 reset", MAXV, 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired count=%0d irq=%0d expected run to end", count, irq);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        do_reset();

        // R1: idle before the first start, with hold and ratio inputs moving
        for (int i = 0; i < 200; i++) begin
            div_hi      = i[3];
            clk_sub_sel = i[5];
            cyc("R1 idle", 1'b0, i[1]);
        end
        clk_sub_sel = 1'b0;
        div_hi      = 1'b0;

        // R3 / R6: main clock /16 over two full periods
        cyc("R2 start", 1'b1, 1'b0);
        for (int i = 0; i < 16 * 32 * 2 + 20; i++) cyc("R3 R6 div16", 1'b0, 1'b0);

        // R4: main clock /128, one full period
        div_hi = 1'b1;
        cyc("R2 start", 1'b1, 1'b0);
        for (int i = 0; i < 128 * 32 + 10; i++) cyc("R4 R6 div128", 1'b0, 1'b0);

        // R5: sub clock, ratio bit set and ignored
        clk_sub_sel = 1'b1;
        cyc("R2 start", 1'b1, 1'b0);
        for (int i = 0; i < 2 * 32 * 3 + 5; i++) cyc("R5 sub div2", 1'b0, 1'b0);
        div_hi = 1'b0;
        for (int i = 0; i < 2 * 32 + 5; i++) cyc("R5 sub div2", 1'b0, 1'b0);

        // R2: kicks at irregular spacing in /16 mode, never reaching underflow
        clk_sub_sel = 1'b0;
        for (int k = 0; k < 6; k++) begin
            cyc("R2 kick", 1'b1, k[0]);
            for (int i = 0; i < 200 + k * 37; i++) cyc("R2 kick run", 1'b0, 1'b0);
        end

        // R7: hold pattern in /16 mode across an underflow
        cyc("R2 start", 1'b1, 1'b0);
        for (int i = 0; i < 1200; i++) cyc("R7 hold", 1'b0, (i % 7) < 3);
        for (int i = 0; i < 40; i++)   cyc("R7 hold long", 1'b0, 1'b1);

        // R8: runs on without strobes, then only reset stops it
        for (int i = 0; i < 300; i++) cyc("R8 free run", 1'b0, 1'b0);
        do_reset();
        for (int i = 0; i < 100; i++) cyc("R8 R1 stopped", 1'b0, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule